// File: doc/BRIEF.md
# Selectable Wait-State Acknowledge Generator

This block ends processor bus cycles on a board whose memory and peripherals all sit on an 8-bit port. It holds a short chain of flip-flops cleared while the active-low address strobe is idle. When the strobe asserts, the chain fills with ones, one stage per processor clock edge. A select input picks the stage that drives the active-low byte-port acknowledge. The choice gives zero, one or two wait states. A bypass input holds the acknowledge asserted all the time, with no counting. The word-port acknowledge is never driven active, so the processor always treats the port as 8 bits wide.

The strobe itself clears the chain. When a cycle ends, the acknowledge therefore releases at once, without waiting for a clock edge, and the next cycle always starts counting from an empty chain.

Top module: `wsg_ack_gen`

## Requirements
- R1: `word_ack_n` is 1 at all times, whatever the inputs are.
- R2: While `strobe_n` is 1 and `ack_bypass` is 0, `byte_ack_n` is 1.
- R3: With `wait_sel` = 0, `byte_ack_n` goes to 0 just after the first rising clock edge that follows the fall of `strobe_n`. It is 1 before that edge.
- R4: With `wait_sel` = 1, `byte_ack_n` goes to 0 just after the second rising clock edge that follows the fall of `strobe_n`.
- R5: With `wait_sel` = 2, `byte_ack_n` goes to 0 just after the third rising clock edge that follows the fall of `strobe_n`.
- R6: `wait_sel` = 3 is reserved and gives the same timing as `wait_sel` = 2.
- R7: Moving `wait_sel` from 0 to 1 and from 1 to 2 lengthens the time from strobe assertion to acknowledge by exactly one clock at each step.
- R8: Once asserted, `byte_ack_n` stays 0 while `strobe_n` stays 0. When `strobe_n` rises, it returns to 1 at once, with no clock edge needed.
- R9: While `ack_bypass` is 1, `byte_ack_n` is 0 continuously, independent of `strobe_n`, `wait_sel` and the clock.
- R10: A rise of `strobe_n` that contains no clock edge still empties the chain. The next cycle counts its full delay again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; the chain advances on its rising edge |
| strobe_n | input | 1 | Active-low address strobe; while high it clears the chain asynchronously |
| wait_sel | input | SEL_W (2) | Wait-state choice: 0, 1, 2 wait states; 3 acts as 2 |
| ack_bypass | input | 1 | When 1, acknowledge is forced asserted |
| byte_ack_n | output | 1 | Active-low byte-port cycle acknowledge |
| word_ack_n | output | 1 | Active-low word-port acknowledge, held inactive |

## Verification
The bench counts rising edges from strobe assertion to acknowledge for every select value. An off-by-one tap, or a chain that needs an extra edge to leave reset, shows up as a count one too high or one too low. It also shows up as a broken one-clock step between settings. Reserved select 3 is measured on its own, so a mux that decodes it to an empty or undriven tap gives a hang or a wrong count. Release is sampled a fraction of a cycle after the strobe rises, and a strobe pulse with no clock inside it is inserted mid-cycle. A design with a synchronous clear would either hold the acknowledge too long or carry stale ones into the next cycle and acknowledge early.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

   // Limit a requested tap index to the last stage of the chain
   function automatic int unsigned wsg_clamp_tap(input int unsigned req,
                                                 input int unsigned last);
      return (req > last) ? last : req;
   endfunction

endpackage

// File: rtl/wsg_shift_chain.sv
module wsg_shift_chain #(
   parameter int unsigned STAGES = 3
) (
   input  logic              clk,
   input  logic              clear_hi,
   output logic [STAGES-1:0] stage_q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("wsg_shift_chain: STAGES must be at least 2");
   end

   // Stage 0 loads a constant one; each later stage copies its neighbour
   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or posedge clear_hi) begin
            if (clear_hi) stage_q[0] <= 1'b0;
            else          stage_q[0] <= 1'b1;
         end
      end else begin : g_body
         always_ff @(posedge clk or posedge clear_hi) begin
            if (clear_hi) stage_q[i] <= 1'b0;
            else          stage_q[i] <= stage_q[i-1];
         end

         // R10
         // stages fill in order: a later stage never holds a one ahead of an earlier one
         thermometer_chk: assert property (@(posedge clk) disable iff (clear_hi)
            stage_q[i] |-> stage_q[i-1]);
      end
   end

   // R8
   // a filled chain stays filled for as long as the strobe is held
   full_hold_chk: assert property (@(posedge clk) disable iff (clear_hi)
      stage_q[STAGES-1] |=> stage_q[STAGES-1]);

endmodule

// File: rtl/wsg_tap_mux.sv
module wsg_tap_mux
   import wsg_pkg::*;
#(
   parameter int unsigned STAGES = 3,
   parameter int unsigned SEL_W  = 2
) (
   input  logic [STAGES-1:0] chain,
   input  logic [SEL_W-1:0]  sel,
   output logic              tap
);

   localparam int unsigned LAST_TAP = STAGES - 1;
   localparam int unsigned IDX_W    = (STAGES > 2) ? $clog2(STAGES) : 1;
   localparam int unsigned SEL_SPAN = 1 << SEL_W;

   if (SEL_W < 1) begin : g_bad_sel
      $error("wsg_tap_mux: SEL_W must be at least 1");
   end

   logic [IDX_W-1:0] idx;

   if (SEL_SPAN > STAGES) begin : g_clamped
      // Reserved codes past the last stage fold onto the longest delay
      always_comb idx = IDX_W'(wsg_clamp_tap(32'(sel), LAST_TAP));
   end else begin : g_direct
      always_comb idx = IDX_W'(sel);
   end

   always_comb tap = chain[idx];

endmodule

// File: rtl/wsg_ack_gen.sv
module wsg_ack_gen #(
   parameter int unsigned STAGES = 3,
   parameter int unsigned SEL_W  = 2
) (
   input  logic             clk,
   input  logic             strobe_n,
   input  logic [SEL_W-1:0] wait_sel,
   input  logic             ack_bypass,
   output logic             byte_ack_n,
   output logic             word_ack_n
);

   if ((1 << SEL_W) < STAGES) begin : g_bad_combo
      $error("wsg_ack_gen: SEL_W too narrow to reach every stage");
   end

   logic [STAGES-1:0] chain_q;
   logic              tap_hit;

   wsg_shift_chain #(.STAGES(STAGES)) u_chain (
      .clk      (clk),
      .clear_hi (strobe_n),
      .stage_q  (chain_q)
   );

   wsg_tap_mux #(.STAGES(STAGES), .SEL_W(SEL_W)) u_mux (
      .chain (chain_q),
      .sel   (wait_sel),
      .tap   (tap_hit)
   );

   always_comb byte_ack_n = ~(tap_hit | ack_bypass);
   always_comb word_ack_n = 1'b1;

   // R3
   // with no wait states, any edge taken inside a cycle leaves the acknowledge asserted
   zero_wait_chk: assert property (@(posedge clk) disable iff (strobe_n)
      (!ack_bypass && wait_sel == '0 && $stable(wait_sel)) |=> !byte_ack_n);

   // R2
   // an idle strobe keeps the acknowledge released unless bypassed
   idle_release_chk: assert property (@(posedge clk)
      (strobe_n && !ack_bypass) |-> byte_ack_n);

endmodule

// File: tb/wsg_ack_gen_test.sv
module wsg_ack_gen_test;

   logic       clk = 1'b0;
   logic       strobe_n = 1'b1;
   logic [1:0] wait_sel = 2'd0;
   logic       ack_bypass = 1'b0;
   logic       byte_ack_n;
   logic       word_ack_n;

   int unsigned checks = 0;
   int unsigned fails  = 0;
   int unsigned cycles = 0;
   int          meas [4];

   always #4 clk = ~clk;

   wsg_ack_gen uut (
      .clk        (clk),
      .strobe_n   (strobe_n),
      .wait_sel   (wait_sel),
      .ack_bypass (ack_bypass),
      .byte_ack_n (byte_ack_n),
      .word_ack_n (word_ack_n)
   );

   task automatic check_bit(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   // Count edges from strobe fall (driven at negedge) until acknowledge
   task automatic count_edges(output int n);
      n = 0;
      while (byte_ack_n === 1'b1 && n < 10) begin
         @(posedge clk); #1;
         n++;
      end
   endtask

   task automatic test_reset_state;
      @(negedge clk); #1;
      check_bit("R2 idle ack", byte_ack_n, 1'b1);
      check_bit("R1 word ack", word_ack_n, 1'b1);
   endtask

   task automatic test_select(input logic [1:0] sel, input string req, input int exp);
      int n;
      @(negedge clk);
      wait_sel = sel;
      strobe_n = 1'b0;
      #1;
      check_bit({req, " before first edge"}, byte_ack_n, 1'b1);
      count_edges(n);
      meas[sel] = n;
      check_int({req, " edges to ack"}, n, exp);
      repeat (3) @(posedge clk);
      #1;
      check_bit("R8 ack held", byte_ack_n, 1'b0);
      check_bit("R1 word ack in cycle", word_ack_n, 1'b1);
      // release between edges: acknowledge must clear with no edge
      @(negedge clk); #1;
      strobe_n = 1'b1;
      #1;
      check_bit("R8 async release", byte_ack_n, 1'b1);
      @(posedge clk); #1;
      check_bit("R2 idle after cycle", byte_ack_n, 1'b1);
   endtask

   task automatic test_step;
      check_int("R7 step 0->1", meas[1] - meas[0], 1);
      check_int("R7 step 1->2", meas[2] - meas[1], 1);
      check_int("R6 sel3 equals sel2", meas[3], meas[2]);
   endtask

   task automatic test_bypass;
      ack_bypass = 1'b1;
      wait_sel = 2'd2;
      #1;
      check_bit("R9 bypass idle strobe", byte_ack_n, 1'b0);
      @(negedge clk);
      strobe_n = 1'b0;
      #1;
      check_bit("R9 bypass strobe low", byte_ack_n, 1'b0);
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); #1;
         check_bit("R9 bypass during cycle", byte_ack_n, 1'b0);
      end
      strobe_n = 1'b1;
      #1;
      check_bit("R9 bypass after strobe", byte_ack_n, 1'b0);
      check_bit("R1 word ack bypass", word_ack_n, 1'b1);
      ack_bypass = 1'b0;
      #1;
      check_bit("R2 bypass removed", byte_ack_n, 1'b1);
   endtask

   task automatic test_short_gap;
      int n;
      @(negedge clk);
      wait_sel = 2'd2;
      strobe_n = 1'b0;
      @(posedge clk); #1;
      // glitch the strobe high with no clock edge inside
      strobe_n = 1'b1;
      #1;
      strobe_n = 1'b0;
      #1;
      check_bit("R10 cleared by short gap", byte_ack_n, 1'b1);
      count_edges(n);
      check_int("R10 full delay after gap", n, 3);
      @(negedge clk);
      strobe_n = 1'b1;
      #1;
      check_bit("R8 release after gap test", byte_ack_n, 1'b1);
   endtask

   initial begin
      test_reset_state();
      test_select(2'd0, "R3", 1);
      test_select(2'd1, "R4", 2);
      test_select(2'd2, "R5", 3);
      test_select(2'd3, "R6", 3);
      test_step();
      test_bypass();
      test_short_gap();
      finish_run();
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         fails++;
         $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
         finish_run();
      end
   end

endmodule